// File: doc/BRIEF.md
# Indirect Table Access Controller

This block gives a host processor with a byte-wide register port access to wide internal tables (a static MAC table, a VLAN table, a dynamic MAC table and a set of MIB counters) through a window of eleven byte registers at offsets 0x79 to 0x83. The host stages a direction, a table select, a 10-bit table address and up to 67 bits of data in those registers. A write to the low-address byte at 0x7A launches the access. The block then issues a one-cycle request on the table-side port that carries select, address, direction and write data.

For a read, the table answers with a valid strobe and a 67-bit word. That word is loaded into every data register at once, and the host then reads it out byte by byte. Dynamic MAC and MIB reads have variable latency, so the top bit of offset 0x7B shows a busy flag while such a read is outstanding. Static MAC and VLAN reads answer within a cycle and never show busy.

The sequencer has four states. IDLE goes to WR_ISSUE on a write launch and to RD_ISSUE on a read launch. WR_ISSUE always returns to IDLE. RD_ISSUE goes to IDLE when the valid strobe arrives and to RD_WAIT otherwise. RD_WAIT stays where it is until the valid strobe arrives, then returns to IDLE.

Top module: `tblwin_ctrl`

## Requirements
- R1: After reset every window register reads 0x00, `tbl_req` is low and the busy flag is clear.
- R2: Offset 0x79 holds the control byte. Bit 4 is the direction (1 = read, 0 = write). Bits 3..2 are the table select (00 static MAC, 01 VLAN, 10 dynamic MAC, 11 MIB). Bits 1..0 are table address bits 9..8. Bits 7..5 always read 0.
- R3: Offset 0x7A holds table address bits 7..0. `tbl_addr` is {0x79 bits 1..0, 0x7A}, `tbl_sel` is 0x79 bits 3..2 and `tbl_rnw` is 0x79 bit 4.
- R4: Offset 0x7B bits 2..0 hold data bits 66..64, and bits 6..3 read 0. Offset 0x7C+j (j = 0..7) holds data bits 63-8j down to 56-8j, so 0x83 holds bits 7..0. Addresses outside 0x79..0x83 read 0x00 and ignore writes.
- R5: A host write to 0x7A while IDLE raises `tbl_req` for exactly one cycle, in the cycle after the write. Writes to any other offset never raise `tbl_req`.
- R6: During the request of a write command, `tbl_wdata` equals the staged 67-bit data. The busy flag stays 0 for writes.
- R7: For a read, `tbl_rvalid` is accepted from the request cycle onward. In the cycle after it, all data registers hold `tbl_rdata`, and the block is back in IDLE.
- R8: Bit 7 of 0x7B reads 1 from the cycle after a read launch until the cycle after `tbl_rvalid`, but only for select 10 or 11. For select 00 or 01 it reads 0 throughout.
- R9: From launch until completion, writes to 0x79 and 0x7A are dropped and produce no new request.
- R10: A `tbl_rvalid` while no read is pending has no effect on the data registers.
- R11: Writes to the data bytes during a pending read are staged, but a `tbl_rvalid` in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe for one byte |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read-back byte for `host_addr` (combinational) |
| tbl_req | output | 1 | One-cycle table request |
| tbl_rnw | output | 1 | 1 = read, 0 = write |
| tbl_sel | output | 2 | Table select |
| tbl_addr | output | 10 | Table entry address |
| tbl_wdata | output | 67 | Write data toward the table |
| tbl_rvalid | input | 1 | Read data valid strobe from the table |
| tbl_rdata | input | 67 | Read data from the table |

## Verification
A behavioural reference model is run alongside the block and compared on every cycle. Write commands with distinct data patterns show whether the byte-to-bit mapping and the request timing are correct. Reads are tried on all four selects with valid returned in the request cycle, one cycle later and several cycles later; these separate the busy-flag policy per table type from the load timing. Pending reads are then hit with control and address writes, data writes and a coincident valid strobe, and stray valid strobes are sent while idle, to expose any lost lock-out or wrong priority.

// File: rtl/tblwin_pkg.sv
package tblwin_pkg;
    localparam int TW_DATA_W = 67;
    localparam int TW_NFULL  = TW_DATA_W / 8;
    localparam int TW_TOPW   = TW_DATA_W - 8 * TW_NFULL;

    localparam logic [7:0] OFS_CTL  = 8'h79;
    localparam logic [7:0] OFS_ALO  = 8'h7A;
    localparam logic [7:0] OFS_STAT = 8'h7B;
    localparam logic [7:0] OFS_D0   = 8'h7C;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_ISSUE,
        ST_RD_ISSUE,
        ST_RD_WAIT
    } tw_state_e;

    typedef struct packed {
        logic       rd;
        logic [1:0] sel;
        logic [1:0] ahi;
    } tw_ctl_t;
endpackage

// File: rtl/tblwin_fsm.sv
module tblwin_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic launch_rd,
    input  logic rvalid,
    output logic issue,
    output logic rd_pend,
    output logic idle
);
    import tblwin_pkg::*;

    tw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (launch) state_d = launch_rd ? ST_RD_ISSUE : ST_WR_ISSUE;
            ST_WR_ISSUE: state_d = ST_IDLE;
            ST_RD_ISSUE: state_d = rvalid ? ST_IDLE : ST_RD_WAIT;
            ST_RD_WAIT:  if (rvalid) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        issue   = 1'b0;
        rd_pend = 1'b0;
        idle    = 1'b0;
        unique case (state_q)
            ST_IDLE:     idle = 1'b1;
            ST_WR_ISSUE: issue = 1'b1;
            ST_RD_ISSUE: begin issue = 1'b1; rd_pend = 1'b1; end
            ST_RD_WAIT:  rd_pend = 1'b1;
        endcase
    end

    assert_launch_issues_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> issue);
    assert_issue_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);
    assert_rvalid_completes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && rvalid) |=> idle);
endmodule

// File: rtl/tblwin_regs.sv
module tblwin_regs
    import tblwin_pkg::*;
#(
    parameter int DATA_W = TW_DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [7:0]          host_addr,
    input  logic [7:0]          host_wdata,
    input  logic                idle,
    input  logic                rd_pend,
    input  logic                tbl_rvalid,
    input  logic [DATA_W-1:0]   tbl_rdata,
    output logic                launch,
    output tw_ctl_t             ctl_q,
    output logic [7:0]          alo_q,
    output logic [DATA_W-1:0]   data_q,
    output logic                status
);
    localparam int NFULL = DATA_W / 8;
    localparam int TOPW  = DATA_W - 8 * NFULL;

    logic load;

    assign launch = host_we && (host_addr == OFS_ALO) && idle;
    assign load   = rd_pend && tbl_rvalid;
    assign status = rd_pend && ctl_q.sel[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            alo_q <= '0;
        end else if (host_we && idle) begin
            if (host_addr == OFS_CTL) ctl_q <= host_wdata[4:0];
            if (host_addr == OFS_ALO) alo_q <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= tbl_rdata;
        end else if (host_we) begin
            if (host_addr == OFS_STAT) data_q[DATA_W-1 -: TOPW] <= host_wdata[TOPW-1:0];
            for (int j = 0; j < NFULL; j++) begin
                if (host_addr == OFS_D0 + 8'(j))
                    data_q[8*(NFULL-1-j) +: 8] <= host_wdata;
            end
        end
    end

    assert_ctl_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && host_we && host_addr == OFS_CTL) |=> $stable(ctl_q));
    assert_load_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && tbl_rvalid) |=> (data_q == $past(tbl_rdata)));
    assert_stray_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pend && !host_we) |=> $stable(data_q));
    assert_busy_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && tbl_rvalid) |=> !status);
endmodule

// File: rtl/tblwin_rdmux.sv
module tblwin_rdmux
    import tblwin_pkg::*;
#(
    parameter int DATA_W = TW_DATA_W
) (
    input  logic [7:0]        host_addr,
    input  tw_ctl_t           ctl_q,
    input  logic [7:0]        alo_q,
    input  logic [DATA_W-1:0] data_q,
    input  logic              status,
    output logic [7:0]        host_rdata
);
    localparam int NFULL = DATA_W / 8;
    localparam int TOPW  = DATA_W - 8 * NFULL;

    always_comb begin
        host_rdata = 8'h00;
        if (host_addr == OFS_CTL) host_rdata = {3'b000, ctl_q};
        if (host_addr == OFS_ALO) host_rdata = alo_q;
        if (host_addr == OFS_STAT) begin
            host_rdata[7]        = status;
            host_rdata[TOPW-1:0] = data_q[DATA_W-1 -: TOPW];
        end
        for (int j = 0; j < NFULL; j++) begin
            if (host_addr == OFS_D0 + 8'(j))
                host_rdata = data_q[8*(NFULL-1-j) +: 8];
        end
    end
endmodule

// File: rtl/tblwin_ctrl.sv
module tblwin_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [7:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        tbl_req,
    output logic        tbl_rnw,
    output logic [1:0]  tbl_sel,
    output logic [9:0]  tbl_addr,
    output logic [66:0] tbl_wdata,
    input  logic        tbl_rvalid,
    input  logic [66:0] tbl_rdata
);
    import tblwin_pkg::*;

    logic    launch, issue, rd_pend, idle, status;
    tw_ctl_t ctl_q;
    logic [7:0] alo_q;
    logic [TW_DATA_W-1:0] data_q;

    tblwin_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .launch_rd (ctl_q.rd),
        .rvalid    (tbl_rvalid),
        .issue     (issue),
        .rd_pend   (rd_pend),
        .idle      (idle)
    );

    tblwin_regs #(.DATA_W(TW_DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .idle       (idle),
        .rd_pend    (rd_pend),
        .tbl_rvalid (tbl_rvalid),
        .tbl_rdata  (tbl_rdata),
        .launch     (launch),
        .ctl_q      (ctl_q),
        .alo_q      (alo_q),
        .data_q     (data_q),
        .status     (status)
    );

    tblwin_rdmux #(.DATA_W(TW_DATA_W)) u_rdmux (
        .host_addr  (host_addr),
        .ctl_q      (ctl_q),
        .alo_q      (alo_q),
        .data_q     (data_q),
        .status     (status),
        .host_rdata (host_rdata)
    );

    assign tbl_req   = issue;
    assign tbl_rnw   = ctl_q.rd;
    assign tbl_sel   = ctl_q.sel;
    assign tbl_addr  = {ctl_q.ahi, alo_q};
    assign tbl_wdata = data_q;
endmodule

// File: tb/tblwin_ctrl_tb_top.sv
module tblwin_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        tbl_req, tbl_rnw;
    logic [1:0]  tbl_sel;
    logic [9:0]  tbl_addr;
    logic [66:0] tbl_wdata;
    logic        tbl_rvalid = 1'b0;
    logic [66:0] tbl_rdata = '0;

    always #10 clk = ~clk;

    tblwin_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .tbl_req(tbl_req),
        .tbl_rnw(tbl_rnw), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string sc = "R1";

    // reference model: phase 0 idle, 1 write issue, 2 read issue, 3 read wait
    int          m_ph = 0;
    logic [4:0]  m_ctl = '0;
    logic [7:0]  m_alo = '0;
    logic [66:0] m_data = '0;

    function automatic logic [7:0] m_read(input logic [7:0] a);
        int pos;
        if (a == 8'h79) return {3'b000, m_ctl};
        if (a == 8'h7A) return m_alo;
        if (a == 8'h7B) return {((m_ph >= 2) && m_ctl[3]), 4'b0000, m_data[66:64]};
        if (a >= 8'h7C && a <= 8'h83) begin
            pos = 8 * (8'h83 - a);
            return 8'((m_data >> pos) & 67'hFF);
        end
        return 8'h00;
    endfunction

    task automatic m_update(input logic we, input logic [7:0] a, input logic [7:0] d,
                            input logic rv, input logic [66:0] rd);
        bit pend = (m_ph >= 2);
        bit idl  = (m_ph == 0);
        bit go   = we && (a == 8'h7A) && idl;
        int nph  = m_ph;
        if (pend && rv) m_data = rd;
        else if (we) begin
            if (a == 8'h7B) m_data[66:64] = d[2:0];
            if (a >= 8'h7C && a <= 8'h83) begin
                for (int b = 0; b < 8; b++) m_data[8*(8'h83 - a) + b] = d[b];
            end
        end
        if (m_ph == 0 && go) nph = m_ctl[4] ? 2 : 1;
        else if (m_ph == 1) nph = 0;
        else if (pend) nph = rv ? 0 : 3;
        if (we && idl && a == 8'h79) m_ctl = d[4:0];
        if (go) m_alo = d;
        m_ph = nph;
    endtask

    task automatic chk(input string what, input logic [66:0] act, input logic [66:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", sc, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("host_rdata", 67'(host_rdata), 67'(m_read(host_addr)));
        chk("tbl_req",    67'(tbl_req),    67'(m_ph == 1 || m_ph == 2));
        chk("tbl_rnw",    67'(tbl_rnw),    67'(m_ctl[4]));
        chk("tbl_sel",    67'(tbl_sel),    67'(m_ctl[3:2]));
        chk("tbl_addr",   67'(tbl_addr),   67'({m_ctl[1:0], m_alo}));
        chk("tbl_wdata",  tbl_wdata,       m_data);
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                        input logic rv, input logic [66:0] rd);
        host_we = we; host_addr = a; host_wdata = d; tbl_rvalid = rv; tbl_rdata = rd;
        @(posedge clk);
        m_update(we, a, d, rv, rd);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, '0);
    endtask

    task automatic peek(input logic [7:0] a);
        step(1'b0, a, 8'h00, 1'b0, '0);
    endtask

    task automatic sweep();
        for (int a = 8'h77; a <= 8'h85; a++) peek(8'(a));
    endtask

    task automatic load_data(input logic [66:0] v);
        wr(8'h7B, {5'b11111, v[66:64]});
        for (int j = 0; j < 8; j++) wr(8'(8'h7C + j), v[63-8*j -: 8]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        sc = "R1 reset";
        sweep();

        sc = "R2 control";
        wr(8'h79, 8'hFF); peek(8'h79);
        sc = "R3 address";
        wr(8'h79, 8'h02); peek(8'h79);
        sc = "R4 data layout";
        load_data(67'h5_0123_4567_89AB_CDEF);
        wr(8'h78, 8'hAA); wr(8'h84, 8'h55);
        sweep();

        sc = "R5 R6 write command";
        wr(8'h79, 8'h06);
        wr(8'h7A, 8'h5A);
        peek(8'h7B); peek(8'h7B); peek(8'h7B);
        sc = "R6 write pattern2";
        load_data(67'h2_FEDC_BA98_7654_3210);
        wr(8'h79, 8'h0B); wr(8'h7A, 8'h01); peek(8'h7B); peek(8'h7B);

        sc = "R7 R8 static read next-cycle valid";
        wr(8'h79, 8'h11); wr(8'h7A, 8'h33);
        peek(8'h7B);
        step(1'b0, 8'h7B, 8'h00, 1'b1, 67'h6_1111_2222_3333_4444);
        sweep();

        sc = "R7 R8 vlan read valid in request cycle";
        wr(8'h79, 8'h14); wr(8'h7A, 8'h80);
        step(1'b0, 8'h7B, 8'h00, 1'b1, 67'h1_A5A5_5A5A_F00F_0FF0);
        sweep();

        sc = "R8 R9 R11 dynamic read pending";
        wr(8'h79, 8'h1B); wr(8'h7A, 8'hC3);
        peek(8'h7B); peek(8'h7B);
        sc = "R9 lockout";
        wr(8'h7A, 8'h11); wr(8'h79, 8'h00); peek(8'h79); peek(8'h7A);
        sc = "R11 staging";
        wr(8'h83, 8'h99); peek(8'h83);
        step(1'b1, 8'h80, 8'h77, 1'b1, 67'h3_DEAD_BEEF_CAFE_F00D);
        sweep();

        sc = "R8 MIB read";
        wr(8'h79, 8'h1C); wr(8'h7A, 8'h07);
        peek(8'h7B); peek(8'h7B); peek(8'h7B);
        step(1'b0, 8'h7B, 8'h00, 1'b1, 67'h4_0000_FFFF_0000_FFFF);
        peek(8'h7B); peek(8'h7C);

        sc = "R10 stray valid";
        step(1'b0, 8'h7C, 8'h00, 1'b1, 67'h7_FFFF_FFFF_FFFF_FFFF);
        step(1'b0, 8'h83, 8'h00, 1'b1, 67'h0_1234_0000_0000_0000);
        sweep();

        sc = "R5 no launch from other offsets";
        for (int k = 0; k < 12; k++) wr(8'(8'h7B + (k % 9)), 8'(k * 37));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule